// File: doc/BRIEF.md
# Dual-Bank Non-Volatile Image Validator

The block decides which of two stored copies of a non-volatile settings image is current. Each copy is 8192 bytes, and the second copy sits at the addresses directly after the first. After a start pulse the block reads every byte of both copies through a byte-wide synchronous read port, one byte per cycle. It tests each copy in three ways: a fixed signature byte, a one-byte header checksum with end-around carry, and a two-accumulator modulo-65521 checksum over the body.

For each copy it reports a valid flag and the copy's 32-bit generation number. An invalid copy reports generation 0. It then names the copy with the larger generation as active. Bank 0 wins a tie.

A boot controller or a flash-update engine would pulse `start` once, wait for `done`, and then read the image from the active bank. The read port expects data one cycle after the address, so a plain synchronous RAM or flash shadow can drive it directly.

Top module: `nvbank_select`

## Requirements
- R1: After an accepted start, `rd_addr` is 0 in the first cycle and rises by one each cycle through 0x3FFF. Byte offset k of bank b is at address b*0x2000+k. `rd_data` must return the addressed byte one cycle later. Outside a scan `rd_addr` is 0.
- R2: A bank whose byte at offset 0 is not 0x5A is invalid.
- R3: The header sum is the signature byte plus the bytes at offsets 2 to 15. While this sum exceeds 0xFF it is replaced by its low byte plus its upper bits. The folded sum must equal the byte at offset 1, or the bank is invalid.
- R4: The body checksum starts with low = 1 and high = 0. For each byte from offset 0x14 to 0x1FFF, low is increased by the byte and then high is increased by low, both modulo 65521. The value {high, low} must equal the big-endian word at offsets 16 to 19, or the bank is invalid.
- R5: The generation is the big-endian word at offsets 20 to 23. `gen0`/`gen1` report it for a valid bank and 0 for an invalid bank. `valid0`/`valid1` flag validity.
- R6: `active_bank` is 1 only when gen0 < gen1 as unsigned numbers. Otherwise it is 0, which covers equal generations and two invalid banks.
- R7: `done` is a one-cycle pulse 16387 rising edges after the edge that accepts `start`. `busy` is high from that edge until `done`. A start while busy is ignored and does not change the timing.
- R8: After reset every output is 0. Results change only at `done` and otherwise hold, even when memory contents change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a scan of both banks (ignored while busy) |
| rd_addr | output | 14 | Byte address into the two-bank image |
| rd_data | input | 8 | Byte read from `rd_addr` one cycle earlier |
| busy | output | 1 | A scan is in progress |
| done | output | 1 | One-cycle pulse: results updated |
| valid0 | output | 1 | Bank 0 passed all checks |
| valid1 | output | 1 | Bank 1 passed all checks |
| gen0 | output | 32 | Bank 0 generation, 0 if invalid |
| gen1 | output | 32 | Bank 1 generation, 0 if invalid |
| active_bank | output | 1 | Selected bank |

## Verification
Address k appears on `rd_addr` k rising edges after the accepting edge. The bench's monitor compares it with its own counter at every falling edge while `busy` is high. The bench counts the rising edges from the accepting edge until `done` is seen on a falling edge, and requires exactly 16387.

All result checks sample at that falling edge, because results and `done` change on the same edge. The hold checks sample again tens of cycles later after the bench has altered the memory. Expected checksums, folds and generations are recomputed in the bench from its own memory model.

// File: rtl/nvb_pkg.sv
// nvb_pkg: constants and arithmetic shared by the image validator.
// Assumes the image layout: signature, header checksum, header bytes,
// body checksum word, generation word, then the body.
package nvb_pkg;
    localparam int unsigned NVB_MOD      = 65521;
    localparam logic [7:0]  NVB_SIG      = 8'h5A;
    localparam int unsigned NVB_OFF_CSUM = 1;
    localparam int unsigned NVB_OFF_HLO  = 2;
    localparam int unsigned NVB_OFF_HHI  = 15;
    localparam int unsigned NVB_OFF_ADL  = 16;
    localparam int unsigned NVB_OFF_GEN  = 20;
    localparam int unsigned NVB_OFF_BODY = 20;

    // Add two residues below NVB_MOD and return the residue of the sum.
    function automatic logic [15:0] nvb_mod_add(input logic [15:0] a, input logic [15:0] b);
        logic [16:0] s;
        s = {1'b0, a} + {1'b0, b};
        if (s >= 17'(NVB_MOD))
            s = s - 17'(NVB_MOD);
        return s[15:0];
    endfunction
endpackage

// File: rtl/nvb_adler.sv
// nvb_adler: running two-accumulator checksum, reduced modulo NVB_MOD at
// every step by one conditional subtraction. Assumes at most one byte per
// cycle; clr has priority over en.
module nvb_adler
    import nvb_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        en,
    input  logic [7:0]  din,
    output logic [31:0] sum_o
);
    logic [15:0] low_q, high_q, low_n, high_n;

    // Next accumulator values for one absorbed byte.
    always_comb begin
        low_n  = nvb_mod_add(low_q, {8'h00, din});
        high_n = nvb_mod_add(high_q, low_n);
    end

    // Accumulator registers: seed on clr, absorb on en.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            low_q  <= 16'd1;
            high_q <= 16'd0;
        end else if (en) begin
            low_q  <= low_n;
            high_q <= high_n;
        end
    end

    assign sum_o = {high_q, low_q};

    assert_acc_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (low_q < 16'(NVB_MOD)) && (high_q < 16'(NVB_MOD)));
endmodule

// File: rtl/nvb_seq.sv
// nvb_seq: address sequencer. Walks both banks one byte per cycle and
// tags each returning byte with its bank and offset. Assumes the read
// port returns data exactly one cycle after the address.
module nvb_seq #(
    parameter  int unsigned IMG_BYTES = 8192,
    localparam int unsigned OW = $clog2(IMG_BYTES),
    localparam int unsigned AW = OW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    output logic [AW-1:0] rd_addr,
    output logic          byte_vld,
    output logic [OW-1:0] byte_off,
    output logic          byte_bank
);
    localparam logic [AW-1:0] LAST = AW'(2 * IMG_BYTES - 1);

    logic          issue_q;
    logic [AW-1:0] cnt_q;
    logic          vld_q;
    logic [AW-1:0] addr_q;

    // Address counter: runs from 0 to LAST once per accepted go.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issue_q <= 1'b0;
            cnt_q   <= '0;
        end else if (!issue_q) begin
            issue_q <= go;
            cnt_q   <= '0;
        end else if (cnt_q == LAST) begin
            issue_q <= 1'b0;
            cnt_q   <= '0;
        end else begin
            cnt_q   <= cnt_q + 1'b1;
        end
    end

    // Tag stage aligned with the one-cycle read latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            addr_q <= '0;
        end else begin
            vld_q  <= issue_q;
            addr_q <= cnt_q;
        end
    end

    assign rd_addr   = cnt_q;
    assign byte_vld  = vld_q;
    assign byte_off  = addr_q[OW-1:0];
    assign byte_bank = addr_q[AW-1];

    assert_idle_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !issue_q |-> rd_addr == '0);
    assert_addr_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_q && $past(issue_q)) |-> rd_addr == $past(rd_addr) + 1'b1);
endmodule

// File: rtl/nvb_check.sv
// nvb_check: validates one bank image from a tagged byte stream. Captures
// signature, header sum, stored checksums and generation, and issues a
// registered verdict one cycle after the last byte. Assumes byte offsets
// arrive in ascending order starting at 0.
module nvb_check
    import nvb_pkg::*;
#(
    parameter  int unsigned IMG_BYTES = 8192,
    localparam int unsigned OW = $clog2(IMG_BYTES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          byte_vld,
    input  logic [OW-1:0] byte_off,
    input  logic          byte_bank,
    input  logic [7:0]    din,
    output logic          res_vld,
    output logic          res_bank,
    output logic          res_ok,
    output logic [31:0]   res_gen
);
    localparam int unsigned   HSW    = 12;
    localparam logic [OW-1:0] O_SIG  = '0;
    localparam logic [OW-1:0] O_CSUM = OW'(NVB_OFF_CSUM);
    localparam logic [OW-1:0] O_HLO  = OW'(NVB_OFF_HLO);
    localparam logic [OW-1:0] O_HHI  = OW'(NVB_OFF_HHI);
    localparam logic [OW-1:0] O_ADL  = OW'(NVB_OFF_ADL);
    localparam logic [OW-1:0] O_ADLE = OW'(NVB_OFF_ADL + 4);
    localparam logic [OW-1:0] O_GEN  = OW'(NVB_OFF_GEN);
    localparam logic [OW-1:0] O_GENE = OW'(NVB_OFF_GEN + 4);
    localparam logic [OW-1:0] O_BODY = OW'(NVB_OFF_BODY);
    localparam logic [OW-1:0] O_LAST = OW'(IMG_BYTES - 1);

    logic           sig_ok_q;
    logic [HSW-1:0] hsum_q;
    logic [7:0]     csum_q;
    logic [31:0]    stored_q, gen_q, adler_sum;
    logic           last_q, last_bank_q;
    logic [8:0]     fold1;
    logic [7:0]     fold2;
    logic           ok;

    nvb_adler u_adler (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (byte_vld && byte_off == O_SIG),
        .en    (byte_vld && byte_off >= O_BODY),
        .din   (din),
        .sum_o (adler_sum)
    );

    // Header field capture by byte offset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sig_ok_q <= 1'b0;
            hsum_q   <= '0;
            csum_q   <= '0;
            stored_q <= '0;
            gen_q    <= '0;
        end else if (byte_vld) begin
            if (byte_off == O_SIG) begin
                sig_ok_q <= (din == NVB_SIG);
                hsum_q   <= HSW'(din);
            end
            if (byte_off == O_CSUM)
                csum_q <= din;
            if (byte_off >= O_HLO && byte_off <= O_HHI)
                hsum_q <= hsum_q + HSW'(din);
            if (byte_off >= O_ADL && byte_off < O_ADLE)
                stored_q <= {stored_q[23:0], din};
            if (byte_off >= O_GEN && byte_off < O_GENE)
                gen_q <= {gen_q[23:0], din};
        end
    end

    // End-around carry fold: two passes bound a 12-bit sum to one byte.
    always_comb begin
        fold1 = {1'b0, hsum_q[7:0]} + {5'b0, hsum_q[11:8]};
        fold2 = fold1[7:0] + {7'b0, fold1[8]};
        ok    = sig_ok_q && (fold2 == csum_q) && (adler_sum == stored_q);
    end

    // Last-byte marker, then the registered verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q      <= 1'b0;
            last_bank_q <= 1'b0;
            res_vld     <= 1'b0;
            res_bank    <= 1'b0;
            res_ok      <= 1'b0;
            res_gen     <= '0;
        end else begin
            last_q      <= byte_vld && byte_off == O_LAST;
            last_bank_q <= byte_bank;
            res_vld     <= last_q;
            if (last_q) begin
                res_bank <= last_bank_q;
                res_ok   <= ok;
                res_gen  <= ok ? gen_q : 32'd0;
            end
        end
    end

    assert_hsum_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hsum_q <= HSW'(15 * 255));
endmodule

// File: rtl/nvbank_select.sv
// nvbank_select: scans two consecutive bank images, validates each and
// selects the bank with the larger generation (bank 0 on a tie). Results
// are published together with a done pulse and held until the next one.
module nvbank_select #(
    parameter  int unsigned IMG_BYTES = 8192,
    localparam int unsigned OW = $clog2(IMG_BYTES),
    localparam int unsigned AW = OW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic [AW-1:0] rd_addr,
    input  logic [7:0]    rd_data,
    output logic          busy,
    output logic          done,
    output logic          valid0,
    output logic          valid1,
    output logic [31:0]   gen0,
    output logic [31:0]   gen1,
    output logic          active_bank
);
    logic          go;
    logic          busy_q;
    logic          byte_vld, byte_bank;
    logic [OW-1:0] byte_off;
    logic          res_vld, res_bank, res_ok;
    logic [31:0]   res_gen;
    logic          st_v0;
    logic [31:0]   st_g0;

    assign go = start && !busy_q;

    nvb_seq #(.IMG_BYTES(IMG_BYTES)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (go),
        .rd_addr   (rd_addr),
        .byte_vld  (byte_vld),
        .byte_off  (byte_off),
        .byte_bank (byte_bank)
    );

    nvb_check #(.IMG_BYTES(IMG_BYTES)) u_check (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_vld  (byte_vld),
        .byte_off  (byte_off),
        .byte_bank (byte_bank),
        .din       (rd_data),
        .res_vld   (res_vld),
        .res_bank  (res_bank),
        .res_ok    (res_ok),
        .res_gen   (res_gen)
    );

    // Scan control, bank 0 staging and result publication.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q      <= 1'b0;
            done        <= 1'b0;
            st_v0       <= 1'b0;
            st_g0       <= '0;
            valid0      <= 1'b0;
            valid1      <= 1'b0;
            gen0        <= '0;
            gen1        <= '0;
            active_bank <= 1'b0;
        end else begin
            done <= 1'b0;
            if (go)
                busy_q <= 1'b1;
            if (res_vld && !res_bank) begin
                st_v0 <= res_ok;
                st_g0 <= res_gen;
            end
            if (res_vld && res_bank) begin
                valid0      <= st_v0;
                gen0        <= st_g0;
                valid1      <= res_ok;
                gen1        <= res_gen;
                active_bank <= (st_g0 < res_gen);
                done        <= 1'b1;
                busy_q      <= 1'b0;
            end
        end
    end

    assign busy = busy_q;

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(gen0) && $stable(gen1) && $stable(valid0)
                  && $stable(valid1) && $stable(active_bank));
    assert_invalid1_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !valid1) |-> !active_bank);
endmodule

// File: tb/nvbank_select_tb.sv
// Directed bench for nvbank_select: a computed two-bank memory model,
// one task per scenario, each checking its own results.
module nvbank_select_tb;
    localparam int IMG = 8192;
    localparam int LAT = 16387;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [13:0] rd_addr;
    logic [7:0]  rd_data;
    logic        busy, done, valid0, valid1, active_bank;
    logic [31:0] gen0, gen1;

    int tests = 0;
    int fails = 0;
    bit finished = 0;

    logic [7:0] hdr [0:1][0:23];
    int seed = 0;

    always #4 clk = ~clk;

    nvbank_select u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_addr(rd_addr),
        .rd_data(rd_data), .busy(busy), .done(done), .valid0(valid0),
        .valid1(valid1), .gen0(gen0), .gen1(gen1), .active_bank(active_bank)
    );

    function automatic logic [7:0] byte_at(input bit b, input int off);
        if (off < 24)
            return hdr[b][off];
        return 8'((off * 7 + (b ? 13 : 0) + seed) & 255);
    endfunction

    // Synchronous read model with one cycle of latency.
    always_ff @(posedge clk)
        rd_data <= byte_at(rd_addr[13], int'(rd_addr[12:0]));

    // R1 monitor: addresses must count up from 0 while busy.
    int exp_a = 0;
    int addr_err = 0;
    always @(negedge clk) begin
        if (!busy)
            exp_a = 0;
        else if (exp_a < 2 * IMG) begin
            if (rd_addr != 14'(exp_a))
                addr_err = addr_err + 1;
            exp_a = exp_a + 1;
        end
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Build one bank image: R2 signature, R3 folded header sum,
    // R4 body checksum stored big-endian at 16, R5 generation at 20.
    task automatic setup_bank(input bit b, input logic [31:0] gen,
                              input bit bad_sig, input bit bad_csum, input bit bad_adl);
        int s;
        longint lo, hi;
        logic [31:0] w;
        for (int i = 0; i < 24; i++) hdr[b][i] = 8'h00;
        hdr[b][0] = bad_sig ? 8'h5B : 8'h5A;
        for (int i = 2; i < 16; i++) hdr[b][i] = 8'(8'hE0 + i * 3 + int'(b));
        for (int i = 0; i < 4; i++) hdr[b][20 + i] = gen[31 - 8 * i -: 8];
        s = int'(hdr[b][0]);
        for (int i = 2; i < 16; i++) s += int'(hdr[b][i]);
        while (s > 255) s = (s & 255) + (s >> 8);
        hdr[b][1] = bad_csum ? 8'(s + 1) : 8'(s);
        lo = 1;
        hi = 0;
        for (int off = 20; off < IMG; off++) begin
            lo += longint'(byte_at(b, off));
            hi += lo;
        end
        w = {16'(hi % 65521), 16'(lo % 65521)};
        if (bad_adl) w = w ^ 32'h1;
        for (int i = 0; i < 4; i++) hdr[b][16 + i] = w[31 - 8 * i -: 8];
    endtask

    task automatic run_scan(input int poke_at, output int lat);
        @(negedge clk) start = 1'b1;
        @(posedge clk);
        @(negedge clk) start = 1'b0;
        lat = 0;
        while (lat < 20000) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
            start = (lat == poke_at);
            if (done) break;
        end
        start = 1'b0;
    endtask

    task automatic t_reset;
        check(busy == 0 && done == 0, "R8", "reset busy/done", {busy, done}, 0);
        check(valid0 == 0 && valid1 == 0, "R8", "reset valids", {valid0, valid1}, 0);
        check(gen0 == 0 && gen1 == 0, "R8", "reset gens", gen0 | gen1, 0);
        check(active_bank == 0 && rd_addr == 0, "R8", "reset bank/addr", rd_addr, 0);
    endtask

    task automatic t_bank1_newer;
        int lat;
        seed = 3;
        setup_bank(0, 32'h7FFF_FFFF, 0, 0, 0);
        setup_bank(1, 32'h8000_0000, 0, 0, 0);
        run_scan(-1, lat);
        check(lat == LAT, "R7", "done latency", lat, LAT);
        check(addr_err == 0, "R1", "address sequence errors", addr_err, 0);
        check(valid0 && valid1, "R4", "both banks valid", {valid0, valid1}, 3);
        check(gen0 == 32'h7FFF_FFFF, "R5", "gen0", gen0, 32'h7FFF_FFFF);
        check(gen1 == 32'h8000_0000, "R5", "gen1", gen1, 32'h8000_0000);
        check(active_bank == 1, "R6", "unsigned newer bank1", active_bank, 1);
        setup_bank(1, 32'd1, 0, 0, 0);
        repeat (40) @(negedge clk);
        check(gen1 == 32'h8000_0000 && active_bank == 1, "R8", "hold after memory change", gen1, 32'h8000_0000);
        check(done == 0 && busy == 0, "R8", "no activity without start", {busy, done}, 0);
    endtask

    task automatic t_bank0_newer_poke;
        int lat;
        seed = 11;
        setup_bank(0, 32'd9, 0, 0, 0);
        setup_bank(1, 32'd5, 0, 0, 0);
        run_scan(100, lat);
        check(lat == LAT, "R7", "latency with start while busy", lat, LAT);
        check(addr_err == 0, "R1", "address sequence errors", addr_err, 0);
        check(active_bank == 0 && gen0 == 9 && gen1 == 5, "R6", "bank0 newer", active_bank, 0);
        repeat (30) @(negedge clk);
        check(busy == 0, "R7", "start while busy ignored", busy, 0);
    endtask

    task automatic t_equal;
        int lat;
        seed = 29;
        setup_bank(0, 32'd7, 0, 0, 0);
        setup_bank(1, 32'd7, 0, 0, 0);
        run_scan(-1, lat);
        check(active_bank == 0 && valid0 && valid1, "R6", "tie picks bank0", active_bank, 0);
    endtask

    task automatic t_bad_sig;
        int lat;
        seed = 5;
        setup_bank(0, 32'd2, 0, 0, 0);
        setup_bank(1, 32'hFFFF_FFF0, 1, 0, 0);
        run_scan(-1, lat);
        check(valid1 == 0, "R2", "bad signature invalid", valid1, 0);
        check(gen1 == 0, "R5", "invalid bank gen zero", gen1, 0);
        check(active_bank == 0 && gen0 == 2, "R6", "bank0 chosen", active_bank, 0);
    endtask

    task automatic t_bad_csum;
        int lat;
        seed = 77;
        setup_bank(0, 32'h8000_0000, 0, 1, 0);
        setup_bank(1, 32'd1, 0, 0, 0);
        run_scan(-1, lat);
        check(valid0 == 0 && gen0 == 0, "R3", "bad header checksum invalid", gen0, 0);
        check(valid1 == 1 && active_bank == 1, "R3", "folded sum accepted, bank1 active", active_bank, 1);
    endtask

    task automatic t_bad_adler;
        int lat;
        seed = 140;
        setup_bank(0, 32'd3, 0, 0, 0);
        setup_bank(1, 32'd50, 0, 0, 1);
        run_scan(-1, lat);
        check(valid1 == 0 && gen1 == 0, "R4", "bad body checksum invalid", gen1, 0);
        check(valid0 == 1 && gen0 == 3 && active_bank == 0, "R4", "good bank0 kept", gen0, 3);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bank1_newer();
        t_bank0_newer_poke();
        t_equal();
        t_bad_sig();
        t_bad_csum();
        t_bad_adler();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule